// File: doc/BRIEF.md
# Floating-point compare flag generator

This block compares two IEEE-754 binary operands and sorts the pair into one of four classes: less, equal, greater or unordered. A format input chooses between 32-bit and 64-bit operands. The class is then written into two condition words at once.

The first is a stack-FPU status word, in which three condition bits change. The second is an integer flags word, in which the carry, parity and zero flags change. In both words the caller supplies the current value, and every other bit passes through untouched.

A mode input chooses a signalling or a quiet compare. The two modes give the same class and the same flag codes. They differ only in when the invalid-operation output is raised. A start strobe launches a compare, and the registered result appears one cycle later with a single-cycle valid pulse.

Top module: `fp_cmp_flags`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its mantissa is nonzero. If either operand is a NaN, the class is unordered (class code 3).
- R2: When neither operand is a NaN, a positive operand is greater than a negative one. Between operands of equal sign, the one with the larger exponent-and-mantissa magnitude is greater when the sign is positive and smaller when the sign is negative. Infinities follow the same rule. Class codes are less = 0, equal = 1, greater = 2.
- R3: Positive zero and negative zero compare equal to each other, in either order.
- R4: The status-word output changes only bits 8, 10 and 14 (mask 0x4500). Less sets bit 8 only, equal sets bit 14 only, greater clears all three, and unordered sets all three.
- R5: The flags-word output changes only bit 0 (carry), bit 2 (parity) and bit 6 (zero). Less sets carry only, equal sets zero only, greater clears all three, and unordered sets all three.
- R6: In both output words, every bit outside the changed positions equals the value supplied on the corresponding input word when start was sampled.
- R7: In signalling mode (quiet_i = 0), invalid_o is raised exactly when at least one operand is a NaN.
- R8: In quiet mode (quiet_i = 1), invalid_o is raised only when an operand is a signalling NaN, that is a NaN whose top mantissa bit is 0. A quiet NaN leaves it low.
- R9: With dbl_i = 1, the full 64 bits are used: sign at bit 63, 11-bit exponent, 52-bit mantissa. With dbl_i = 0, only bits 31:0 are used: sign at bit 31, 8-bit exponent, 23-bit mantissa. In this format bits 63:32 have no effect.
- R10: On a clock edge where start_i is high, all results are registered, and valid_o is high for the following cycle only. Without start_i, the results hold their values.
- R11: After reset, valid_o, invalid_o, class_o, sw_o and fl_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a compare on this edge |
| dbl_i | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands in bits 31:0 |
| quiet_i | input | 1 | 1 = quiet compare, 0 = signalling compare |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| sw_i | input | SW_W | Current status word |
| fl_i | input | FL_W | Current flags word |
| valid_o | output | 1 | Result valid, one cycle after start |
| class_o | output | 2 | Class: 0 less, 1 equal, 2 greater, 3 unordered |
| sw_o | output | SW_W | Updated status word |
| fl_o | output | FL_W | Updated flags word |
| invalid_o | output | 1 | Invalid-operation indication |

## Verification
The bench builds the block with its default widths: a 16-bit status word and a 32-bit flags word. With these widths the bench can fill every bit of both words with random values, so a lost pass-through bit in either word would be seen. The operand mix weights quiet NaNs, signalling NaNs, both zeros, infinities and repeated operands in both formats, with random junk in the upper half for 32-bit compares. This puts every class, and both invalid rules, within reach of the random loop as well as the directed cases.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int OPND_W   = 1 + DP_EXP_W + DP_MAN_W;
    localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;
    localparam int MAG_W    = OPND_W - 1;

    // condition bit positions decoded by the consumers of each word
    localparam int SW_C0_BIT = 8;
    localparam int SW_C2_BIT = 10;
    localparam int SW_C3_BIT = 14;
    localparam int FL_CF_BIT = 0;
    localparam int FL_PF_BIT = 2;
    localparam int FL_ZF_BIT = 6;

    typedef enum logic [1:0] {
        CLS_LT = 2'd0,
        CLS_EQ = 2'd1,
        CLS_GT = 2'd2,
        CLS_UN = 2'd3
    } cmp_class_e;

    typedef struct packed {
        logic             sign;
        logic             zero;
        logic             nan;
        logic             snan;
        logic [MAG_W-1:0] mag;
    } opnd_info_t;

    typedef struct packed {
        logic lo;   // status bit 8 / carry
        logic un;   // status bit 10 / parity
        logic eq;   // status bit 14 / zero
    } cond_bits_t;

    function automatic cond_bits_t class_to_cond(input cmp_class_e cls);
        cond_bits_t c;
        c = '0;
        unique case (cls)
            CLS_LT: c.lo = 1'b1;
            CLS_EQ: c.eq = 1'b1;
            CLS_GT: c = '0;
            default: begin
                c.lo = 1'b1;
                c.un = 1'b1;
                c.eq = 1'b1;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] raw_i,
    output opnd_info_t           info_o
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic [MAG_W-1:0] mag_ext;
    logic             is_nan;

    assign exp_f  = raw_i[W-2:MAN_W];
    assign man_f  = raw_i[MAN_W-1:0];
    assign is_nan = (&exp_f) & (|man_f);

    always_comb begin
        mag_ext        = '0;
        mag_ext[W-2:0] = raw_i[W-2:0];
    end

    always_comb begin
        info_o.sign = raw_i[W-1];
        info_o.zero = ~(|raw_i[W-2:0]);
        info_o.nan  = is_nan;
        info_o.snan = is_nan & ~man_f[MAN_W-1];
        info_o.mag  = mag_ext;
    end
endmodule

// File: rtl/fpcmp_operand.sv
module fpcmp_operand
    import fpcmp_pkg::*;
(
    input  logic              dbl_i,
    input  logic [OPND_W-1:0] raw_i,
    output opnd_info_t        info_o
);
    opnd_info_t sp_info;
    opnd_info_t dp_info;

    fpcmp_unpack #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_sp (
        .raw_i  (raw_i[SP_W-1:0]),
        .info_o (sp_info)
    );

    fpcmp_unpack #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_dp (
        .raw_i  (raw_i),
        .info_o (dp_info)
    );

    assign info_o = dbl_i ? dp_info : sp_info;
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  opnd_info_t a_i,
    input  opnd_info_t b_i,
    input  logic       quiet_i,
    output cmp_class_e cls_o,
    output logic       invalid_o
);
    logic any_nan;
    logic any_snan;
    logic mag_lt;

    assign any_nan  = a_i.nan | b_i.nan;
    assign any_snan = a_i.snan | b_i.snan;
    assign mag_lt   = a_i.mag < b_i.mag;

    assign invalid_o = quiet_i ? any_snan : any_nan;

    always_comb begin
        if (any_nan)
            cls_o = CLS_UN;
        else if (a_i.zero && b_i.zero)
            cls_o = CLS_EQ;
        else if (a_i.sign != b_i.sign)
            cls_o = a_i.sign ? CLS_LT : CLS_GT;
        else if (a_i.mag == b_i.mag)
            cls_o = CLS_EQ;
        else if (mag_lt ^ a_i.sign)
            cls_o = CLS_LT;
        else
            cls_o = CLS_GT;
    end
endmodule

// File: rtl/fpcmp_encode.sv
module fpcmp_encode
    import fpcmp_pkg::*;
#(
    parameter int SW_W = 16,
    parameter int FL_W = 32
) (
    input  cmp_class_e      cls_i,
    input  logic [SW_W-1:0] sw_i,
    input  logic [FL_W-1:0] fl_i,
    output logic [SW_W-1:0] sw_o,
    output logic [FL_W-1:0] fl_o
);
    localparam logic [SW_W-1:0] SW_MASK = (SW_W'(1) << SW_C0_BIT) |
                                          (SW_W'(1) << SW_C2_BIT) |
                                          (SW_W'(1) << SW_C3_BIT);
    localparam logic [FL_W-1:0] FL_MASK = (FL_W'(1) << FL_CF_BIT) |
                                          (FL_W'(1) << FL_PF_BIT) |
                                          (FL_W'(1) << FL_ZF_BIT);

    cond_bits_t      cond;
    logic [SW_W-1:0] sw_code;
    logic [FL_W-1:0] fl_code;

    assign cond = class_to_cond(cls_i);

    always_comb begin
        sw_code            = '0;
        sw_code[SW_C0_BIT] = cond.lo;
        sw_code[SW_C2_BIT] = cond.un;
        sw_code[SW_C3_BIT] = cond.eq;
        fl_code            = '0;
        fl_code[FL_CF_BIT] = cond.lo;
        fl_code[FL_PF_BIT] = cond.un;
        fl_code[FL_ZF_BIT] = cond.eq;
    end

    assign sw_o = (sw_i & ~SW_MASK) | sw_code;
    assign fl_o = (fl_i & ~FL_MASK) | fl_code;
endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags
    import fpcmp_pkg::*;
#(
    parameter int SW_W = 16,
    parameter int FL_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              dbl_i,
    input  logic              quiet_i,
    input  logic [OPND_W-1:0] opa_i,
    input  logic [OPND_W-1:0] opb_i,
    input  logic [SW_W-1:0]   sw_i,
    input  logic [FL_W-1:0]   fl_i,
    output logic              valid_o,
    output logic [1:0]        class_o,
    output logic [SW_W-1:0]   sw_o,
    output logic [FL_W-1:0]   fl_o,
    output logic              invalid_o
);
    localparam int N_OPND = 2;

    logic [OPND_W-1:0] raw [N_OPND];
    opnd_info_t        info [N_OPND];

    cmp_class_e        cls_c;
    logic              inv_c;
    logic [SW_W-1:0]   sw_c;
    logic [FL_W-1:0]   fl_c;

    cmp_class_e        cls_q;
    logic              inv_q;
    logic              valid_q;
    logic [SW_W-1:0]   sw_q;
    logic [FL_W-1:0]   fl_q;

    assign raw[0] = opa_i;
    assign raw[1] = opb_i;

    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        fpcmp_operand u_opnd (
            .dbl_i  (dbl_i),
            .raw_i  (raw[i]),
            .info_o (info[i])
        );
    end

    fpcmp_order u_order (
        .a_i       (info[0]),
        .b_i       (info[1]),
        .quiet_i   (quiet_i),
        .cls_o     (cls_c),
        .invalid_o (inv_c)
    );

    fpcmp_encode #(.SW_W(SW_W), .FL_W(FL_W)) u_encode (
        .cls_i (cls_c),
        .sw_i  (sw_i),
        .fl_i  (fl_i),
        .sw_o  (sw_c),
        .fl_o  (fl_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cls_q   <= CLS_LT;
            inv_q   <= 1'b0;
            sw_q    <= '0;
            fl_q    <= '0;
        end else begin
            valid_q <= start_i;
            if (start_i) begin
                cls_q <= cls_c;
                inv_q <= inv_c;
                sw_q  <= sw_c;
                fl_q  <= fl_c;
            end
        end
    end

    assign valid_o   = valid_q;
    assign class_o   = cls_q;
    assign invalid_o = inv_q;
    assign sw_o      = sw_q;
    assign fl_o      = fl_q;
endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker
    import fpcmp_pkg::*;
#(
    parameter int SW_W = 16,
    parameter int FL_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic            quiet_i,
    input logic [SW_W-1:0] sw_i,
    input logic [FL_W-1:0] fl_i,
    input logic            valid_o,
    input logic [1:0]      class_o,
    input logic [SW_W-1:0] sw_o,
    input logic [FL_W-1:0] fl_o,
    input logic            invalid_o
);
    localparam logic [SW_W-1:0] SW_KEEP = ~((SW_W'(1) << SW_C0_BIT) |
                                            (SW_W'(1) << SW_C2_BIT) |
                                            (SW_W'(1) << SW_C3_BIT));
    localparam logic [FL_W-1:0] FL_KEEP = ~((FL_W'(1) << FL_CF_BIT) |
                                            (FL_W'(1) << FL_PF_BIT) |
                                            (FL_W'(1) << FL_ZF_BIT));

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o); // R10
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !valid_o); // R10
    AST_HOLD_WITHOUT_START: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(sw_o) && $stable(fl_o) && $stable(class_o) && $stable(invalid_o))); // R10
    AST_SW_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        start_i |=> ((sw_o & SW_KEEP) == ($past(sw_i) & SW_KEEP))); // R6
    AST_FL_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        start_i |=> ((fl_o & FL_KEEP) == ($past(fl_i) & FL_KEEP))); // R6
    AST_WORDS_AGREE: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (sw_o[SW_C0_BIT] == fl_o[FL_CF_BIT] && sw_o[SW_C2_BIT] == fl_o[FL_PF_BIT]
                     && sw_o[SW_C3_BIT] == fl_o[FL_ZF_BIT])); // R5
    AST_INVALID_NEEDS_NAN: assert property (@(posedge clk) disable iff (rst)
        (valid_o && invalid_o) |-> (class_o == 2'd3)); // R8
    AST_SIGNALLING_INVALID: assert property (@(posedge clk) disable iff (rst)
        (start_i && !quiet_i) |=> (invalid_o == (class_o == 2'd3))); // R7
endmodule

bind fp_cmp_flags fpcmp_checker #(.SW_W(SW_W), .FL_W(FL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .quiet_i   (quiet_i),
    .sw_i      (sw_i),
    .fl_i      (fl_i),
    .valid_o   (valid_o),
    .class_o   (class_o),
    .sw_o      (sw_o),
    .fl_o      (fl_o),
    .invalid_o (invalid_o)
);

// File: tb/fp_cmp_flags_test.sv
module fp_cmp_flags_test;
    localparam int SW_W = 16;
    localparam int FL_W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start_i = 1'b0;
    logic            dbl_i = 1'b0;
    logic            quiet_i = 1'b0;
    logic [63:0]     opa_i = '0;
    logic [63:0]     opb_i = '0;
    logic [SW_W-1:0] sw_i = '0;
    logic [FL_W-1:0] fl_i = '0;
    logic            valid_o;
    logic [1:0]      class_o;
    logic [SW_W-1:0] sw_o;
    logic [FL_W-1:0] fl_o;
    logic            invalid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [SW_W-1:0] last_sw;
    logic [FL_W-1:0] last_fl;

    fp_cmp_flags #(.SW_W(SW_W), .FL_W(FL_W)) uut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic bit f_nan(input bit dbl, input logic [63:0] x);
        if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic bit f_snan(input bit dbl, input logic [63:0] x);
        return f_nan(dbl, x) && !(dbl ? x[51] : x[22]);
    endfunction

    // map to an unsigned key whose order matches numeric order
    function automatic logic [64:0] f_key(input bit dbl, input logic [63:0] x);
        logic [64:0] m;
        bit s;
        s = dbl ? x[63] : x[31];
        m = dbl ? {2'b0, x[62:0]} : {34'b0, x[30:0]};
        if (s) return 65'h1_0000_0000_0000_0000 - m;
        return 65'h1_0000_0000_0000_0000 + m;
    endfunction

    function automatic logic [1:0] f_class(input bit dbl, input logic [63:0] a, input logic [63:0] b);
        logic [64:0] ka, kb;
        if (f_nan(dbl, a) || f_nan(dbl, b)) return 2'd3;
        ka = f_key(dbl, a);
        kb = f_key(dbl, b);
        if (ka < kb) return 2'd0;
        if (ka == kb) return 2'd1;
        return 2'd2;
    endfunction

    function automatic logic [SW_W-1:0] f_sw(input logic [1:0] c, input logic [SW_W-1:0] old);
        logic [SW_W-1:0] code;
        case (c)
            2'd0: code = 16'h0100;
            2'd1: code = 16'h4000;
            2'd2: code = 16'h0000;
            default: code = 16'h4500;
        endcase
        return (old & ~16'h4500) | code;
    endfunction

    function automatic logic [FL_W-1:0] f_fl(input logic [1:0] c, input logic [FL_W-1:0] old);
        logic [FL_W-1:0] code;
        case (c)
            2'd0: code = 32'h01;
            2'd1: code = 32'h40;
            2'd2: code = 32'h00;
            default: code = 32'h45;
        endcase
        return (old & ~32'h45) | code;
    endfunction

    function automatic logic [63:0] f_rand_op(input bit dbl);
        logic [63:0] r;
        int kind;
        r = {$urandom, $urandom};
        kind = $urandom % 8;
        if (dbl) begin
            case (kind)
                0: r[62:51] = 12'hFFF;                                    // quiet NaN
                1: begin r[62:51] = 12'hFFE; r[0] = 1'b1; end             // signalling NaN
                2: r[62:0] = '0;                                          // zero
                3: begin r[62:52] = 11'h7FF; r[51:0] = '0; end            // infinity
                default: ;
            endcase
        end else begin
            case (kind)
                0: r[30:22] = 9'h1FF;
                1: begin r[30:22] = 9'h1FE; r[0] = 1'b1; end
                2: r[30:0] = '0;
                3: begin r[30:23] = 8'hFF; r[22:0] = '0; end
                default: ;
            endcase
        end
        return r;
    endfunction

    task automatic do_cmp(input string tag, input bit dbl, input bit quiet,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic [SW_W-1:0] sw, input logic [FL_W-1:0] fl);
        logic [1:0] ec;
        bit         einv;
        ec   = f_class(dbl, a, b);
        einv = quiet ? (f_snan(dbl, a) || f_snan(dbl, b)) : (f_nan(dbl, a) || f_nan(dbl, b));
        @(negedge clk);
        dbl_i = dbl; quiet_i = quiet; opa_i = a; opb_i = b; sw_i = sw; fl_i = fl;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " R10 valid"}, 64'(valid_o), 64'd1);
        chk({tag, " class"}, 64'(class_o), 64'(ec));
        chk({tag, " R4 R6 status word"}, 64'(sw_o), 64'(f_sw(ec, sw)));
        chk({tag, " R5 R6 flags word"}, 64'(fl_o), 64'(f_fl(ec, fl)));
        chk({tag, " R7 R8 invalid"}, 64'(invalid_o), 64'(einv));
        last_sw = f_sw(ec, sw);
        last_fl = f_fl(ec, fl);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset valid", 64'(valid_o), 64'd0);
        chk("R11 reset class", 64'(class_o), 64'd0);
        chk("R11 reset status", 64'(sw_o), 64'd0);
        chk("R11 reset flags", 64'(fl_o), 64'd0);
        chk("R11 reset invalid", 64'(invalid_o), 64'd0);

        // directed corners
        do_cmp("R3 +0 vs -0 single", 0, 0, 64'h0000_0000_0000_0000, 64'h0000_0000_8000_0000, 16'hFFFF, 32'hFFFF_FFFF);
        do_cmp("R3 -0 vs +0 double", 1, 1, 64'h8000_0000_0000_0000, 64'h0, 16'h0000, 32'h0);
        do_cmp("R2 1.0 lt 2.0 single", 0, 0, 64'h3F80_0000, 64'h4000_0000, 16'hA5A5, 32'h1234_5678);
        do_cmp("R2 -1.0 gt -2.0 double", 1, 0, 64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 16'h4500, 32'h45);
        do_cmp("R2 -inf lt +inf single", 0, 0, 64'hFF80_0000, 64'h7F80_0000, 16'h0, 32'h0);
        do_cmp("R2 equal doubles", 1, 0, 64'h4009_21FB_5444_2D18, 64'h4009_21FB_5444_2D18, 16'h1234, 32'hDEAD_BEEF);
        do_cmp("R1 R8 qNaN quiet", 0, 1, 64'h7FC0_0000, 64'h3F80_0000, 16'h0, 32'h0);
        do_cmp("R1 R7 qNaN signalling", 0, 0, 64'h3F80_0000, 64'h7FC0_0001, 16'h0, 32'h0);
        do_cmp("R1 R8 sNaN quiet double", 1, 1, 64'h7FF0_0000_0000_0001, 64'h0, 16'hFFFF, 32'hFFFF_FFFF);
        do_cmp("R9 single ignores upper bits", 0, 0, 64'h7FF8_0000_3F80_0000, 64'hFFFF_FFFF_3F80_0000, 16'h0, 32'h0);
        do_cmp("R9 double uses full width", 1, 0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0001, 16'h0, 32'h0);

        // R10: outputs hold and valid stays low without start
        @(negedge clk);
        opa_i = '1; opb_i = '0; sw_i = '0; fl_i = '0; quiet_i = ~quiet_i;
        @(negedge clk);
        chk("R10 valid low without start", 64'(valid_o), 64'd0);
        chk("R10 status held", 64'(sw_o), 64'(last_sw));
        chk("R10 flags held", 64'(fl_o), 64'(last_fl));

        // random mix
        for (int i = 0; i < 600; i++) begin
            bit          d;
            logic [63:0] a, b;
            d = $urandom % 2;
            a = f_rand_op(d);
            b = ($urandom % 6 == 0) ? a : f_rand_op(d);
            if (!d && ($urandom % 2 == 1)) b[63:32] = $urandom;
            do_cmp("R1 R2 R3 R9 random", d, 1'($urandom % 2), a, b, 16'($urandom), $urandom);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule